// File: doc/BRIEF.md
# Power-of-Two Outbound Address Translator

This block remaps CPU-side request addresses onto bus-side addresses through a small table of translation windows. Every window covers a span whose length is a power of two. The span is fixed by a log2 exponent that is stored next to the source base. Because of this, a region whose length is not a power of two must be split across several windows. Software fills each window through a word-addressed write port. The windows sit at a fixed stride of register words.

A lookup is combinational. A request address hits a window when it agrees with that window's source base on every bit at or above the window's exponent. On a hit, the block puts the translated base on those upper bits, keeps the request's own offset bits below the exponent, and reports the window's attribute word and index. On a miss, it raises an error flag and drives no translation.

Top module: `pow2_xlate`

## Requirements
- R1: After reset every window is disabled, so every valid request misses until a window is written.
- R2: A window with exponent E covers 2^E bytes. A request hits it when request and source base are equal on bits 31 down to E. The source base is taken from bits 31:12 of the source-low register, and base bits below E are not compared.
- R3: On a hit, the output address is the translated base on bits 31 down to E and the request address on bits below E. Bits 11:0 of the translated-low write are discarded.
- R4: On a hit, the block reports the winning window's 32-bit attribute word on `rsp_attr` and its number on `rsp_win`.
- R5: When several windows match, the lowest-numbered one is reported.
- R6: The exponent is bits 5:0 of the source-low register. Only values 12 through 32 enable the window. The value 0, values 1 to 11 (below 4 KiB) and values above 32 leave the window disabled and non-matching.
- R7: A valid request that hits no window gives `rsp_miss`=1, `rsp_hit`=0, `rsp_addr`=0, `rsp_attr`=0 and `rsp_win`=0. When `req_valid` is low, both flags are low.
- R8: The register word for window N, register k, is at N*STRIDE+k. The values of k are 0 for source low, 1 for source high, 2 for translated low, 3 for translated high and 4 for attribute. Writes to k=1, k=3 and any k of 5 or more change nothing.
- R9: A write becomes visible to lookups only after the clock edge that captures it. A lookup in the same cycle as the write still uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(NWIN*STRIDE) | Register word address |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 32 | CPU-side request address |
| rsp_hit | output | 1 | Request matched a window |
| rsp_miss | output | 1 | Valid request matched no window |
| rsp_addr | output | 32 | Translated bus-side address |
| rsp_attr | output | 32 | Attribute word of the winning window |
| rsp_win | output | $clog2(NWIN) | Number of the winning window |

## Verification
A configuration write and a lookup can happen in the same cycle, and a lookup may target the very window being rewritten. The bench provokes this case on every write. It holds a request on the address under change while the write strobe is high. It then judges the output before the capturing edge against the old table contents and, after that edge, against the new ones. Overlapping windows and disabled exponent codes are swept with the same address lists, so priority and enable decisions are compared on identical addresses.

// File: rtl/pow2_xlate.sv
module pow2_xlate #(
  parameter int NWIN    = 8,
  parameter int STRIDE  = 8,
  parameter int MIN_EXP = 12,
  localparam int AW = $clog2(NWIN*STRIDE),
  localparam int SW = $clog2(STRIDE),
  localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_valid,
  input  logic [31:0]   req_addr,
  output logic          rsp_hit,
  output logic          rsp_miss,
  output logic [31:0]   rsp_addr,
  output logic [31:0]   rsp_attr,
  output logic [IW-1:0] rsp_win
);

  // STRIDE must be a power of two and at least 8 so that k fits the field.
  logic [31:MIN_EXP] src_q  [NWIN];
  logic [31:MIN_EXP] trl_q  [NWIN];
  logic [5:0]        exp_q  [NWIN];
  logic [31:0]       attr_q [NWIN];
  logic [31:0]       msk    [NWIN];
  logic [NWIN-1:0]   match;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic sel;
    logic en;
    assign sel = cfg_we && (cfg_addr[AW-1:SW] == (AW-SW)'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q[w]  <= '0;
        trl_q[w]  <= '0;
        exp_q[w]  <= '0;
        attr_q[w] <= '0;
      end else if (sel) begin
        case (cfg_addr[SW-1:0])
          SW'(0): begin
            src_q[w] <= cfg_wdata[31:MIN_EXP];
            exp_q[w] <= cfg_wdata[5:0];
          end
          SW'(2): trl_q[w]  <= cfg_wdata[31:MIN_EXP];
          SW'(4): attr_q[w] <= cfg_wdata;
          default: ;
        endcase
      end
    end

    always_comb
      for (int b = 0; b < 32; b++) msk[w][b] = (6'(b) >= exp_q[w]);

    assign en = (exp_q[w] >= 6'(MIN_EXP)) && (exp_q[w] <= 6'd32);
    assign match[w] = en &&
      (((req_addr[31:MIN_EXP] ^ src_q[w]) & msk[w][31:MIN_EXP]) == '0);
  end

  logic          any;
  logic [IW-1:0] pick;

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int w = NWIN-1; w >= 0; w--)
      if (match[w]) begin
        any  = 1'b1;
        pick = IW'(w);
      end
  end

  assign rsp_hit  = req_valid && any;
  assign rsp_miss = req_valid && !any;
  assign rsp_win  = rsp_hit ? pick : '0;
  assign rsp_attr = rsp_hit ? attr_q[pick] : '0;
  assign rsp_addr = rsp_hit ?
    (({trl_q[pick], MIN_EXP'(0)} & msk[pick]) | (req_addr & ~msk[pick])) : '0;

  assert_hit_miss_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss));
  assert_flags_need_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid == (rsp_hit || rsp_miss));
  assert_miss_drives_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_addr == 32'd0 && rsp_attr == 32'd0 && rsp_win == '0));
  assert_page_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_addr[MIN_EXP-1:0] == req_addr[MIN_EXP-1:0]));

endmodule

// File: tb/pow2_xlate_test.sv
`timescale 1ns/1ps
module pow2_xlate_test;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_hit, rsp_miss;
  logic [31:0] rsp_addr, rsp_attr;
  logic [1:0]  rsp_win;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_src [NW];
  logic [31:0] m_trl [NW];
  logic [31:0] m_attr[NW];
  logic [5:0]  m_exp [NW];
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  pow2_xlate #(.NWIN(NW), .STRIDE(8), .MIN_EXP(12)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_addr(rsp_addr),
    .rsp_attr(rsp_attr), .rsp_win(rsp_win));

  function automatic logic [31:0] next_rng(logic [31:0] x);
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(string tag);
    logic hit = 0; logic [31:0] ea = 0, eat = 0; logic [1:0] ew = 0;
    for (int w = 0; w < NW; w++) begin
      logic [31:0] mk;
      if (hit || m_exp[w] < 12 || m_exp[w] > 32) continue;
      mk = (m_exp[w] == 32) ? 32'h0 : ~((32'h1 << m_exp[w]) - 32'h1);
      if (((req_addr ^ m_src[w]) & mk) == 0) begin
        hit = 1; ew = 2'(w); eat = m_attr[w];
        ea = (m_trl[w] & mk) | (req_addr & ~mk);
      end
    end
    hit = hit & req_valid;
    if (!hit) begin ea = 0; eat = 0; ew = 0; end
    tests++;
    if (rsp_hit !== hit || rsp_miss !== (req_valid & !hit) || rsp_addr !== ea ||
        rsp_attr !== eat || rsp_win !== ew) begin
      fails++;
      $display("FAIL %s addr=%h: got hit=%b miss=%b out=%h attr=%h win=%0d exp hit=%b miss=%b out=%h attr=%h win=%0d",
        tag, req_addr, rsp_hit, rsp_miss, rsp_addr, rsp_attr, rsp_win,
        hit, req_valid & !hit, ea, eat, ew);
    end
  endtask

  task automatic look(logic [31:0] a, string tag);
    @(negedge clk); req_valid = 1; req_addr = a; #1 check(tag);
  endtask

  task automatic wr(int win, int k, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 5'(win*8 + k); cfg_wdata = d;
    req_valid = 1; req_addr = m_src[win] | 32'h0000_0ABC;
    #1 check("R9 same-cycle old view");
    @(posedge clk); #0.5;
    case (k)
      0: begin m_src[win] = d & 32'hFFFF_F000; m_exp[win] = d[5:0]; end
      2: m_trl[win] = d & 32'hFFFF_F000;
      4: m_attr[win] = d;
      default: ;
    endcase
    @(negedge clk); cfg_we = 0; #1 check("R9 new view after edge");
  endtask

  task automatic sweep(string tag, int n, logic [3:0] top, bit force_top);
    for (int i = 0; i < n; i++) begin
      rng = next_rng(rng);
      look(force_top ? {top, rng[27:0]} : rng, tag);
    end
  endtask

  task automatic edges(int w, string tag);
    logic [31:0] base = m_src[w];
    logic [31:0] sz = (m_exp[w] >= 32) ? 32'h0 : (32'h1 << m_exp[w]);
    look(base - 1, tag); look(base, tag);
    look(base + sz - 1, tag); look(base + sz, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_src[w] = 0; m_trl[w] = 0; m_attr[w] = 0; m_exp[w] = 0;
    end
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    // R1: reset leaves all windows disabled
    sweep("R1 reset miss", 40, 4'h0, 0);
    look(32'h0, "R1 reset miss zero");
    @(negedge clk); req_valid = 0; #1 check("R7 idle no flags");

    // R2/R3/R4/R5 overlapping windows
    wr(0, 0, 32'h1000_0000 | 24);
    wr(0, 2, 32'h8000_0000);
    wr(0, 4, 32'hA0A0_0000);
    wr(1, 0, 32'h1000_0000 | 28);
    wr(1, 2, 32'h4000_0000);
    wr(1, 4, 32'hA1A1_0001);
    wr(2, 0, 32'h2345_6000 | 12);
    wr(2, 2, 32'hC000_0ABC);
    wr(2, 4, 32'hA2A2_0002);
    wr(3, 0, 32'h3000_0000 | 11);
    wr(3, 4, 32'hA3A3_0003);
    for (int w = 0; w < 3; w++) edges(w, "R2 R3 boundaries");
    sweep("R5 overlap priority", 120, 4'h1, 1);
    sweep("R2 random miss/hit", 60, 4'h0, 0);
    look(32'h2345_6FFF, "R3 low trl bits dropped");

    // R6 disable codes
    look(32'h3000_0000, "R6 exp 11 disabled");
    wr(3, 0, 32'h3000_0000 | 33);
    look(32'h3000_0000, "R6 exp 33 disabled");
    wr(3, 0, 32'h3000_0000);
    look(32'h3000_0000, "R6 exp 0 disabled");
    wr(3, 0, 32'h3000_0000 | 32);
    look(32'h3000_0000, "R6 exp 32 whole space");
    look(32'hFFFF_FFFF, "R6 exp 32 whole space");
    look(32'h1000_0010, "R5 lower index beats w3");
    sweep("R5 full-space fallback", 40, 4'h0, 0);
    wr(3, 0, 32'h0);

    // R2 base bits below exponent ignored
    wr(2, 0, 32'h2345_7000 | 13);
    edges(2, "R2 misaligned base");
    look(32'h2345_6000, "R2 misaligned base");

    // R8 ignored register slots
    wr(0, 1, 32'hFFFF_FFFF);
    wr(0, 3, 32'hFFFF_FFFF);
    wr(0, 5, 32'hDEAD_BEEF);
    wr(0, 6, 32'hDEAD_BEEF);
    wr(0, 7, 32'hDEAD_BEEF);
    edges(0, "R8 ignored slots");
    look(32'h1012_3456, "R8 ignored slots");
    @(negedge clk); req_valid = 0; #1 check("R7 idle no flags");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule